// File: doc/BRIEF.md
# SAR ADC Sequencing Controller

This block is the digital sequencer for a 10-bit successive-approximation converter with eight multiplexed analog inputs. It divides the bus clock into a conversion clock. For each conversion it spends one conversion-clock period sampling and ten periods resolving bits, most significant bit first. It drives the analog multiplexer select and the DAC trial code, and it reads back a one-bit comparator decision. The comparator, DAC and multiplexer sit outside the block.

A conversion starts from a software strobe, from a chosen edge of an external trigger pin, or from a timer match pulse. In single mode the block converts the lowest-numbered selected channel once. In burst mode it keeps cycling through the selected channels with no further triggers. Every channel keeps its own result slot with a done flag and an overrun flag, so software can collect results in batches. A one-cycle interrupt pulse marks each completed conversion. A power-down input stops all activity.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset, `busy`, `irq` and `sampleEn` are 0, `dacCode` is 0, and every channel reads back done=0 and overrun=0.
- R2: A conversion tries each bit from bit 9 down to bit 0. A bit is kept when `cmpIn` is 1, meaning the input is at or above the present trial code. The stored result therefore equals the largest code that the comparator accepts.
- R3: With divider setting `clkDiv`=N, one conversion-clock period lasts N+1 bus cycles. The result and done flag appear exactly 11*(N+1) bus cycles after the edge that accepts the start, and `busy` is still 1 one cycle before that.
- R4: During the first conversion-clock period of a conversion, `sampleEn` is 1 and `dacCode` is 0. `muxSel` carries the channel number and holds it for the whole conversion.
- R5: When `burstEn`=0, one trigger converts only the lowest-index channel set in `chanMask`, and the block then returns to idle.
- R6: When `burstEn`=1, conversions run back to back over the set channels in ascending index order. Clear bits are skipped, and the order wraps from the highest set channel to the lowest. When `burstEn` is cleared, the block finishes the conversion in progress and then stops.
- R7: `trigMode` selects the start source: 0 is a `startSw` pulse, 1 is a rising edge of `extTrig`, 2 is a falling edge of `extTrig`, and 3 is a `timerMatch` pulse. `extTrig` passes through a two-flop synchronizer. Sources that the mode does not select have no effect.
- R8: A trigger that arrives while `busy`=1 is ignored.
- R9: Selecting a channel on `rdChan` shows its result and flags on the read outputs. Setting `rdEn` for one cycle clears that channel's done and overrun flags. A new result written while done=1 sets overrun.
- R10: `irq` is high for exactly one cycle, in the cycle after each result is written.
- R11: While `powerDown`=1, any running conversion is abandoned without writing a result, `busy` drops on the next cycle, and no trigger or burst request starts a conversion.
- R12: When `chanMask` is 0, no conversion starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| powerDown | input | 1 | Stops and blocks conversions |
| clkDiv | input | DIV_W | Conversion clock period minus one, in bus cycles |
| chanMask | input | 8 | Channel selection, bit i = channel i |
| burstEn | input | 1 | Continuous scanning enable |
| trigMode | input | 2 | Start source select |
| startSw | input | 1 | Software start pulse |
| extTrig | input | 1 | Asynchronous external trigger pin |
| timerMatch | input | 1 | Timer match pulse, synchronous |
| cmpIn | input | 1 | Comparator: 1 when input >= dacCode |
| muxSel | output | 3 | Analog multiplexer select |
| dacCode | output | 10 | DAC trial code |
| sampleEn | output | 1 | Sample phase of the conversion |
| busy | output | 1 | Conversion in progress |
| rdEn | input | 1 | Read strobe, clears flags of rdChan |
| rdChan | input | 3 | Channel shown on the read outputs |
| rdData | output | 10 | Result of rdChan |
| rdDone | output | 1 | Done flag of rdChan |
| rdOverrun | output | 1 | Overrun flag of rdChan |
| irq | output | 1 | Conversion-complete pulse |

## Verification
The bench uses a comparator model that checks a per-channel target value against `dacCode`. It sweeps every channel at three divider settings, using the full-scale code, zero and scattered values. An off-by-one error in the bit sequence or in the keep rule gives wrong codes at the extremes. A divider that counts N instead of N+1 shifts the exact done cycle. The burst test watches the order of `muxSel` at each sample phase over a sparse mask, which exposes a missed wrap or a visited unselected channel. Further tests cover each trigger source against the modes that must ignore it, a restart while busy that would cause a false overrun, and a power-down partway through a conversion that must leave no result behind.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int RES_BITS = 10;
  localparam int CH_NUM   = 8;
  localparam int CH_W     = $clog2(CH_NUM);
  localparam int BIT_W    = $clog2(RES_BITS + 1);
  localparam int STEP_W   = $clog2(RES_BITS + 1);

  typedef enum logic [1:0] {
    TRIG_SW    = 2'd0,
    TRIG_RISE  = 2'd1,
    TRIG_FALL  = 2'd2,
    TRIG_TIMER = 2'd3
  } trigSrc_t;

  typedef struct packed {
    logic             clear;
    logic             decide;
    logic             finish;
    logic             trialOn;
    logic [BIT_W-1:0] bitPos;
    logic [CH_W-1:0]  chan;
  } sarStrobe_t;
endpackage

// File: rtl/sar_seq_ctl.sv
module sar_seq_ctl
  import sar_seq_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerDown,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [CH_NUM-1:0] chanMask,
  input  logic              burstEn,
  input  logic [1:0]        trigMode,
  input  logic              startSw,
  input  logic              extTrig,
  input  logic              timerMatch,
  output sarStrobe_t        strobe,
  output logic              busy,
  output logic              sampleEn,
  output logic [CH_W-1:0]   muxSel
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(RES_BITS);

  logic [2:0]        trigSync;
  logic              trigRise, trigFall, trigHit, wantStart, tick, lastStep, anySel;
  logic [STEP_W-1:0] step;
  logic [DIV_W-1:0]  divCnt;
  logic [CH_W-1:0]   curChan;

  function automatic logic [CH_W-1:0] pickChan(input logic [CH_NUM-1:0] mask,
                                               input logic [CH_W-1:0] cur,
                                               input logic fromStart);
    logic [CH_W-1:0] first, nxt;
    logic gotFirst, gotNext;
    first = '0; nxt = '0; gotFirst = 1'b0; gotNext = 1'b0;
    for (int i = 0; i < CH_NUM; i++) begin
      if (mask[i] && !gotFirst) begin first = CH_W'(i); gotFirst = 1'b1; end
      if (mask[i] && !gotNext && i > int'(cur)) begin nxt = CH_W'(i); gotNext = 1'b1; end
    end
    return (fromStart || !gotNext) ? first : nxt;
  endfunction

  // two-flop synchronizer plus a history flop for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) trigSync <= '0;
    else       trigSync <= {trigSync[1:0], extTrig};
  end
  assign trigRise = trigSync[1] & ~trigSync[2];
  assign trigFall = ~trigSync[1] & trigSync[2];

  always_comb begin
    unique case (trigSrc_t'(trigMode))
      TRIG_SW:    trigHit = startSw;
      TRIG_RISE:  trigHit = trigRise;
      TRIG_FALL:  trigHit = trigFall;
      TRIG_TIMER: trigHit = timerMatch;
      default:    trigHit = 1'b0;
    endcase
  end

  assign anySel    = |chanMask;
  assign wantStart = !busy && !powerDown && anySel && (burstEn || trigHit);
  assign tick      = busy && (divCnt == clkDiv);
  assign lastStep  = (step == LAST_STEP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0; step <= '0; divCnt <= '0; curChan <= '0;
    end else if (wantStart) begin
      busy <= 1'b1; step <= '0; divCnt <= '0;
      curChan <= pickChan(chanMask, curChan, 1'b1);
    end else if (busy) begin
      if (powerDown) begin
        busy <= 1'b0; step <= '0; divCnt <= '0;
      end else if (tick) begin
        divCnt <= '0;
        if (lastStep) begin
          step <= '0;
          if (burstEn && anySel) curChan <= pickChan(chanMask, curChan, 1'b0);
          else                   busy    <= 1'b0;
        end else begin
          step <= step + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.clear   = wantStart || (tick && lastStep && !powerDown && burstEn && anySel);
    strobe.decide  = tick && !powerDown && (step != '0);
    strobe.finish  = tick && !powerDown && lastStep;
    strobe.trialOn = busy && (step != '0);
    strobe.bitPos  = BIT_W'(RES_BITS - int'(step));
    strobe.chan    = curChan;
  end

  assign sampleEn = busy && (step == '0);
  assign muxSel   = curChan;

  p_pd_stops_r11: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> !busy);
  p_no_mask_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && chanMask == '0) |=> !busy);
  p_chan_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && step != '0) |-> $stable(curChan));
  p_sample_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> sampleEn);
  p_busy_trig_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !tick) |=> $stable(curChan));
endmodule

// File: rtl/sar_seq_dp.sv
module sar_seq_dp
  import sar_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  sarStrobe_t          strobe,
  input  logic                cmpIn,
  input  logic                rdEn,
  input  logic [CH_W-1:0]     rdChan,
  output logic [RES_BITS-1:0] dacCode,
  output logic [RES_BITS-1:0] rdData,
  output logic                rdDone,
  output logic                rdOverrun,
  output logic                irq
);
  logic [RES_BITS-1:0] sarReg, trialVec, convResult;
  logic [RES_BITS-1:0] resData [CH_NUM];
  logic [CH_NUM-1:0]   doneVec, ovrVec, rdHit, wrHit;

  assign trialVec   = strobe.trialOn ? ({{(RES_BITS-1){1'b0}}, 1'b1} << strobe.bitPos) : '0;
  assign dacCode    = sarReg | trialVec;
  assign convResult = sarReg | (cmpIn ? trialVec : '0);

  always_ff @(posedge clk) begin
    if (!rstN)                         sarReg <= '0;
    else if (strobe.clear)             sarReg <= '0;
    else if (strobe.decide && cmpIn)   sarReg <= sarReg | trialVec;
  end

  always_comb begin
    for (int c = 0; c < CH_NUM; c++) begin
      rdHit[c] = rdEn && (rdChan == CH_W'(c));
      wrHit[c] = strobe.finish && (strobe.chan == CH_W'(c));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneVec <= '0; ovrVec <= '0;
      for (int c = 0; c < CH_NUM; c++) resData[c] <= '0;
    end else begin
      for (int c = 0; c < CH_NUM; c++) begin
        if (wrHit[c]) begin
          resData[c] <= convResult;
          doneVec[c] <= 1'b1;
          ovrVec[c]  <= doneVec[c] && !rdHit[c];
        end else if (rdHit[c]) begin
          doneVec[c] <= 1'b0;
          ovrVec[c]  <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= strobe.finish;
  end

  assign rdData    = resData[rdChan];
  assign rdDone    = doneVec[rdChan];
  assign rdOverrun = ovrVec[rdChan];

  p_done_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> doneVec[$past(strobe.chan)]);
  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !(strobe.finish && strobe.chan == rdChan)) |=> !doneVec[$past(rdChan)]);
  p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
  p_sample_dac_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.trialOn) |-> (dacCode == {1'b1, {(RES_BITS-1){1'b0}}}));
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                powerDown,
  input  logic [DIV_W-1:0]    clkDiv,
  input  logic [CH_NUM-1:0]   chanMask,
  input  logic                burstEn,
  input  logic [1:0]          trigMode,
  input  logic                startSw,
  input  logic                extTrig,
  input  logic                timerMatch,
  input  logic                cmpIn,
  output logic [CH_W-1:0]     muxSel,
  output logic [RES_BITS-1:0] dacCode,
  output logic                sampleEn,
  output logic                busy,
  input  logic                rdEn,
  input  logic [CH_W-1:0]     rdChan,
  output logic [RES_BITS-1:0] rdData,
  output logic                rdDone,
  output logic                rdOverrun,
  output logic                irq
);
  sarStrobe_t strobe;

  sar_seq_ctl #(.DIV_W(DIV_W)) u_ctl (
    .clk(clk), .rstN(rstN), .powerDown(powerDown), .clkDiv(clkDiv),
    .chanMask(chanMask), .burstEn(burstEn), .trigMode(trigMode),
    .startSw(startSw), .extTrig(extTrig), .timerMatch(timerMatch),
    .strobe(strobe), .busy(busy), .sampleEn(sampleEn), .muxSel(muxSel)
  );

  sar_seq_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpIn(cmpIn),
    .rdEn(rdEn), .rdChan(rdChan), .dacCode(dacCode), .rdData(rdData),
    .rdDone(rdDone), .rdOverrun(rdOverrun), .irq(irq)
  );
endmodule

// File: tb/sar_seq_ctrl_test.sv
`timescale 1ns/1ps
module sar_seq_ctrl_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic powerDown = 0, burstEn = 0, startSw = 0, extTrig = 0, timerMatch = 0, rdEn = 0;
  logic [7:0] clkDiv = 0, chanMask = 0;
  logic [1:0] trigMode = 0;
  logic [2:0] rdChan = 0, muxSel;
  logic [9:0] dacCode, rdData;
  logic cmpIn, sampleEn, busy, rdDone, rdOverrun, irq;
  logic [9:0] vin [8];
  int total = 0, bad = 0, irqCount = 0, seqN = 0;
  int seqLog [16];
  logic prevSample = 0;

  always #2.5 clk = ~clk;

  sar_seq_ctrl uut (.*);

  assign cmpIn = (vin[muxSel] >= dacCode);

  always @(negedge clk) begin
    if (rstN && irq) irqCount++;
    if (rstN && sampleEn && !prevSample && seqN < 16) begin seqLog[seqN] = int'(muxSel); seqN++; end
    prevSample <= sampleEn;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 5000) begin tick(1); n++; end
    if (n >= 5000) chk("watch idle", 1, 0);
  endtask

  task automatic peek(input int ch);
    rdChan = 3'(ch);
    #1;
  endtask

  task automatic readClear(input int ch);
    peek(ch);
    rdEn = 1; tick(1); rdEn = 0;
  endtask

  task automatic pulseSw();
    startSw = 1; tick(1); startSw = 0;
  endtask

  function automatic logic [9:0] pat(input int ch, input int k, input int d);
    case (k)
      0: return 10'd0;
      1: return 10'd1023;
      2: return 10'((ch * 73 + d * 31 + 512) % 1024);
      default: return 10'((ch * 97 + d * 211 + 389) % 1024);
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) vin[i] = 10'd0;
    tick(3); rstN = 1; tick(1);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 sampleEn", int'(sampleEn), 0);
    chk("R1 dacCode", int'(dacCode), 0);
    for (int c = 0; c < 8; c++) begin
      peek(c);
      chk("R1 done", int'(rdDone), 0);
      chk("R1 overrun", int'(rdOverrun), 0);
    end

    // R2/R3/R4/R10 sweep: divider, channel, code
    for (int d = 0; d < 3; d++) begin
      clkDiv = 8'(d);
      for (int ch = 0; ch < 8; ch++) begin
        for (int k = 0; k < 4; k++) begin
          vin[ch] = pat(ch, k, d);
          chanMask = 8'(1 << ch);
          rdChan = 3'(ch);
          pulseSw();
          if (k == 0) begin
            chk("R4 sampleEn", int'(sampleEn), 1);
            chk("R4 muxSel", int'(muxSel), ch);
            chk("R4 dacCode", int'(dacCode), 0);
            tick(11 * (d + 1) - 1);
            chk("R3 busy before", int'(busy), 1);
            chk("R3 done before", int'(rdDone), 0);
            tick(1);
            chk("R3 done at", int'(rdDone), 1);
            chk("R5 idle after", int'(busy), 0);
            chk("R10 irq high", int'(irq), 1);
            tick(1);
            chk("R10 irq low", int'(irq), 0);
          end else begin
            waitIdle();
          end
          peek(ch);
          chk("R2 result", int'(rdData), int'(vin[ch]));
          chk("R9 done", int'(rdDone), 1);
          readClear(ch);
          chk("R9 done cleared", int'(rdDone), 0);
        end
      end
    end

    // R5 lowest selected channel only
    clkDiv = 0;
    vin[3] = 10'd345; vin[5] = 10'd77; vin[6] = 10'd900;
    chanMask = 8'b0110_1000;
    pulseSw(); waitIdle(); tick(3);
    chk("R5 still idle", int'(busy), 0);
    peek(3); chk("R5 ch3 done", int'(rdDone), 1); chk("R5 ch3 data", int'(rdData), 345);
    peek(5); chk("R5 ch5 untouched", int'(rdDone), 0);
    peek(6); chk("R5 ch6 untouched", int'(rdDone), 0);
    readClear(3);

    // R12 empty mask
    chanMask = 0;
    pulseSw(); tick(2);
    chk("R12 sw no start", int'(busy), 0);
    burstEn = 1; tick(3);
    chk("R12 burst no start", int'(busy), 0);
    burstEn = 0;

    // R7 trigger sources
    chanMask = 8'b0000_0100; vin[2] = 10'd300;
    trigMode = 2'd1;
    pulseSw(); tick(2);
    chk("R7 sw ignored in rise mode", int'(busy), 0);
    extTrig = 1; tick(3);
    chk("R7 rise starts", int'(busy), 1);
    waitIdle();
    peek(2); chk("R7 rise result", int'(rdData), 300);
    readClear(2);
    extTrig = 0; tick(5);
    chk("R7 fall ignored in rise mode", int'(busy), 0);
    trigMode = 2'd2;
    extTrig = 1; tick(5);
    chk("R7 rise ignored in fall mode", int'(busy), 0);
    extTrig = 0; tick(3);
    chk("R7 fall starts", int'(busy), 1);
    waitIdle(); readClear(2);
    trigMode = 2'd3;
    extTrig = 1; tick(5); extTrig = 0; tick(5);
    chk("R7 pin ignored in timer mode", int'(busy), 0);
    timerMatch = 1; tick(1); timerMatch = 0;
    chk("R7 timer starts", int'(busy), 1);
    waitIdle(); readClear(2);
    trigMode = 2'd0;

    // R8 trigger while busy
    clkDiv = 1; chanMask = 8'b0001_0000; vin[4] = 10'd612;
    begin
      int base;
      base = irqCount;
      pulseSw(); tick(5);
      pulseSw(); tick(3);
      pulseSw();
      waitIdle(); tick(4);
      chk("R8 still idle", int'(busy), 0);
      chk("R8 one completion", irqCount - base, 1);
      peek(4); chk("R8 no overrun", int'(rdOverrun), 0);
      readClear(4);
    end

    // R9 overrun
    clkDiv = 0; chanMask = 8'b0100_0000;
    vin[6] = 10'd111; pulseSw(); waitIdle();
    vin[6] = 10'd222; pulseSw(); waitIdle();
    peek(6);
    chk("R9 overrun set", int'(rdOverrun), 1);
    chk("R9 latest data", int'(rdData), 222);
    readClear(6);
    chk("R9 overrun cleared", int'(rdOverrun), 0);
    chk("R9 done cleared again", int'(rdDone), 0);

    // R11 power-down
    clkDiv = 3; chanMask = 8'b0000_0001; vin[0] = 10'd500;
    pulseSw(); tick(10);
    powerDown = 1; tick(1);
    chk("R11 abort", int'(busy), 0);
    tick(60);
    peek(0); chk("R11 no result", int'(rdDone), 0);
    pulseSw(); tick(2);
    chk("R11 sw blocked", int'(busy), 0);
    burstEn = 1; tick(3);
    chk("R11 burst blocked", int'(busy), 0);
    burstEn = 0; powerDown = 0; tick(2);

    // R6 burst scan
    clkDiv = 0; chanMask = 8'b1010_0110;
    vin[1] = 10'd11; vin[2] = 10'd222; vin[5] = 10'd555; vin[7] = 10'd1000;
    begin
      int base, expSeq [4];
      expSeq = '{1, 2, 5, 7};
      base = irqCount; seqN = 0;
      burstEn = 1; tick(95); burstEn = 0;
      waitIdle(); tick(2);
      chk("R6 enough starts", int'(seqN >= 8), 1);
      for (int i = 0; i < 8; i++) chk("R6 scan order", seqLog[i], expSeq[i % 4]);
      chk("R10 burst irq count", irqCount - base, seqN);
      for (int i = 0; i < 4; i++) begin
        peek(expSeq[i]);
        chk("R6 burst data", int'(rdData), int'(vin[expSeq[i]]));
        readClear(expSeq[i]);
      end
      peek(0); chk("R6 skipped ch0", int'(rdDone), 0);
      peek(3); chk("R6 skipped ch3", int'(rdDone), 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule